// File: doc/BRIEF.md
# Embedded Message Length Extractor

This block sits beside the receive path of an OUT endpoint that runs in automatic transfer-length mode. It watches the bytes of incoming packets and picks out a two-byte message length. That length sits at a programmed byte offset inside the packet. The byte at the offset is taken as the low byte, and the byte after it is taken as the high byte. The block writes the two bytes into the upper half of a 32-bit buffer length word. Each byte has its own done flag.

The length field may straddle a packet boundary. If the low byte is the last byte of a packet, the high byte is the first byte of the next packet. When a new transfer descriptor is loaded, a one-cycle clear pulse rearms the block.

A small state machine drives the capture. It has three states:
- `ST_HUNT_LO`: count byte positions and wait for the offset.
- `ST_WAIT_HI`: the low byte is held, so the next accepted byte is the high byte.
- `ST_HELD`: both bytes are held and capture has stopped.

It has these transitions:
- HUNT_LO→WAIT_HI when an accepted byte sits at the offset.
- WAIT_HI→HELD on the next accepted byte.
- Any state→HUNT_LO on the clear pulse.

Top module: `msg_len_capture`

## Requirements
- R1: A byte is accepted only when `xfer_len_mode` and `ep_dir_out` are both 1 and `byte_vld` is 1. In any other case, the flags and `buf_len[31:16]` keep their values.
- R2: `pkt_first` marks byte index 0 of a packet. An offset of 0 selects that byte as the low length byte.
- R3: The accepted byte at index `len_ofs` is written to `buf_len[23:16]`. `lo_done` reads 1 from the next clock edge onward.
- R4: The first accepted byte after the low byte is written to `buf_len[31:24]`. `hi_done` reads 1 from the next clock edge onward.
- R5: When both flags are 1, further bytes change neither the flags nor `buf_len[31:16]`. `hi_done` is never 1 while `lo_done` is 0.
- R6: If the low byte ends a packet, the high byte is the first byte of the next packet, which is the byte with `pkt_first` set. `lo_done` stays 1 across the boundary.
- R7: `desc_clr` sets both flags and `buf_len[31:16]` to zero at the next edge. Any byte accepted in the same cycle is discarded.
- R8: While the low byte is not yet captured, the position count restarts at each `pkt_first`. An offset past the end of a packet therefore captures nothing in that packet.
- R9: `buf_len[15:0]` always equals `base_len` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_len_mode | input | 1 | Automatic transfer-length mode enable |
| ep_dir_out | input | 1 | Endpoint is an OUT endpoint |
| desc_clr | input | 1 | Clear pulse at descriptor load |
| len_ofs | input | OFS_W | Byte offset of the length field inside the packet |
| byte_vld | input | 1 | Byte strobe |
| pkt_first | input | 1 | The strobed byte is the first byte of a packet |
| byte_data | input | 8 | Packet byte |
| base_len | input | 16 | Lower half of the buffer length word |
| buf_len | output | 32 | Buffer length word with the captured length in bits 31:16 |
| lo_done | output | 1 | Low length byte captured |
| hi_done | output | 1 | High length byte captured |

## Verification
The clear pulse and a byte capture can occur in the same cycle. The bench provokes this with directed cases and with random strobes at random points in a descriptor. It asserts `desc_clr` together with a valid byte exactly at the programmed offset, and also together with the byte that would complete the high half. It expects all-zero flags and upper bits afterwards, because the clear must win. A second overlap is a packet start that coincides with a capture at offset 0 or with a high byte that crosses a boundary. The bench model checks this overlap after every byte.

// File: rtl/mlx_pkg.sv
package mlx_pkg;
    typedef enum logic [1:0] {
        ST_HUNT_LO = 2'd0,
        ST_WAIT_HI = 2'd1,
        ST_HELD    = 2'd2
    } mlx_state_e;
endpackage

// File: rtl/mlx_pos_counter.sv
module mlx_pos_counter #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic             first,
    output logic [CNT_W-1:0] eff_pos
);
    localparam logic [CNT_W-1:0] POS_MAX = '1;

    logic [CNT_W-1:0] pos_q;

    // index of the current byte: a packet start forces position zero
    always_comb begin
        eff_pos = first ? '0 : pos_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (clr) begin
            pos_q <= '0;
        end else if (adv) begin
            pos_q <= (eff_pos == POS_MAX) ? POS_MAX : eff_pos + 1'b1;
        end
    end
endmodule

// File: rtl/mlx_ctrl.sv
module mlx_ctrl
    import mlx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       take,
    input  logic       hit,
    output mlx_state_e state,
    output logic       cap_lo,
    output logic       cap_hi,
    output logic       hunting
);
    mlx_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT_LO;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cap_lo  = 1'b0;
        cap_hi  = 1'b0;
        hunting = 1'b0;
        if (clr) begin
            state_d = ST_HUNT_LO;
        end else begin
            unique case (state_q)
                ST_HUNT_LO: begin
                    hunting = take;
                    if (take && hit) begin
                        cap_lo  = 1'b1;
                        state_d = ST_WAIT_HI;
                    end
                end
                ST_WAIT_HI: begin
                    if (take) begin
                        cap_hi  = 1'b1;
                        state_d = ST_HELD;
                    end
                end
                ST_HELD: begin
                    state_d = ST_HELD;
                end
                default: state_d = ST_HUNT_LO;
            endcase
        end
    end

    assign state = state_q;
endmodule

// File: rtl/mlx_field_reg.sv
module mlx_field_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       cap_lo,
    input  logic       cap_hi,
    input  logic [7:0] din,
    output logic [7:0] lo_byte,
    output logic [7:0] hi_byte,
    output logic       lo_flag,
    output logic       hi_flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_byte <= '0;
            hi_byte <= '0;
            lo_flag <= 1'b0;
            hi_flag <= 1'b0;
        end else if (clr) begin
            lo_byte <= '0;
            hi_byte <= '0;
            lo_flag <= 1'b0;
            hi_flag <= 1'b0;
        end else begin
            if (cap_lo) begin
                lo_byte <= din;
                lo_flag <= 1'b1;
            end
            if (cap_hi) begin
                hi_byte <= din;
                hi_flag <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/msg_len_capture.sv
module msg_len_capture
    import mlx_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_len_mode,
    input  logic             ep_dir_out,
    input  logic             desc_clr,
    input  logic [OFS_W-1:0] len_ofs,
    input  logic             byte_vld,
    input  logic             pkt_first,
    input  logic [7:0]       byte_data,
    input  logic [15:0]      base_len,
    output logic [31:0]      buf_len,
    output logic             lo_done,
    output logic             hi_done
);
    localparam int CNT_W = OFS_W + 1;

    logic             take;
    logic             hit;
    logic             cap_lo;
    logic             cap_hi;
    logic             hunting;
    logic [CNT_W-1:0] eff_pos;
    logic [7:0]       lo_byte;
    logic [7:0]       hi_byte;
    mlx_state_e       state;

    assign take = byte_vld && xfer_len_mode && ep_dir_out;
    assign hit  = (eff_pos == {1'b0, len_ofs});

    mlx_pos_counter #(.CNT_W(CNT_W)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (desc_clr),
        .adv     (hunting),
        .first   (pkt_first),
        .eff_pos (eff_pos)
    );

    mlx_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (desc_clr),
        .take    (take),
        .hit     (hit),
        .state   (state),
        .cap_lo  (cap_lo),
        .cap_hi  (cap_hi),
        .hunting (hunting)
    );

    mlx_field_reg u_fld (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (desc_clr),
        .cap_lo  (cap_lo),
        .cap_hi  (cap_hi),
        .din     (byte_data),
        .lo_byte (lo_byte),
        .hi_byte (hi_byte),
        .lo_flag (lo_done),
        .hi_flag (hi_done)
    );

    assign buf_len = {hi_byte, lo_byte, base_len};

    AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
        hi_done |-> lo_done); // R5
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        desc_clr |=> (!lo_done && !hi_done && buf_len[31:16] == 16'h0)); // R7
    AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_done && !desc_clr) |=> $stable(buf_len[31:16])); // R5
    AST_IDLE_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !desc_clr) |=> ($stable(buf_len[31:16]) && $stable(lo_done) && $stable(hi_done))); // R1
    AST_LO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_done && !desc_clr) |=> (lo_done && $stable(buf_len[23:16]))); // R6
    AST_STATE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD) |-> (lo_done && hi_done)); // R4
endmodule

// File: tb/sim_msg_len_capture.sv
module sim_msg_len_capture;
    localparam int OFS_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             xfer_len_mode = 1'b0;
    logic             ep_dir_out = 1'b0;
    logic             desc_clr = 1'b0;
    logic [OFS_W-1:0] len_ofs = '0;
    logic             byte_vld = 1'b0;
    logic             pkt_first = 1'b0;
    logic [7:0]       byte_data = '0;
    logic [15:0]      base_len = '0;
    logic [31:0]      buf_len;
    logic             lo_done;
    logic             hi_done;

    int n_run = 0;
    int n_fail = 0;

    // model state, built from the requirements
    logic [7:0] m_lo, m_hi;
    logic       m_lf, m_hf;
    int         m_pos;

    msg_len_capture #(.OFS_W(OFS_W)) u0 (
        .clk(clk), .rst_n(rst_n), .xfer_len_mode(xfer_len_mode), .ep_dir_out(ep_dir_out),
        .desc_clr(desc_clr), .len_ofs(len_ofs), .byte_vld(byte_vld), .pkt_first(pkt_first),
        .byte_data(byte_data), .base_len(base_len), .buf_len(buf_len),
        .lo_done(lo_done), .hi_done(hi_done)
    );

    always #10 clk = ~clk;

    function automatic logic [33:0] expect_vec(logic [15:0] base);
        return {m_hf, m_lf, m_hi, m_lo, base};
    endfunction

    task automatic check(string tag);
        logic [33:0] exp_v, act_v;
        exp_v = expect_vec(base_len);
        act_v = {hi_done, lo_done, buf_len};
        n_run++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act_v, exp_v);
        end
    endtask

    task automatic model_clear();
        m_lo = '0; m_hi = '0; m_lf = 1'b0; m_hf = 1'b0; m_pos = 0;
    endtask

    // applies one cycle of stimulus to the model
    task automatic model_step(logic clr, logic vld, logic first, logic [7:0] d);
        int ep;
        if (clr) begin
            model_clear();
        end else if (vld && xfer_len_mode && ep_dir_out) begin
            if (!m_lf) begin
                ep = first ? 0 : m_pos;
                if (ep == int'(len_ofs)) begin
                    m_lo = d; m_lf = 1'b1;
                end
                m_pos = ep + 1;
            end else if (!m_hf) begin
                m_hi = d; m_hf = 1'b1;
            end
        end
    endtask

    task automatic cycle(logic clr, logic vld, logic first, logic [7:0] d, string tag);
        @(negedge clk);
        desc_clr = clr; byte_vld = vld; pkt_first = first; byte_data = d;
        base_len = 16'($urandom);
        model_step(clr, vld, first, d);
        @(negedge clk);
        desc_clr = 1'b0; byte_vld = 1'b0; pkt_first = 1'b0;
        check(tag);
    endtask

    task automatic send_pkt(int len, logic [7:0] seed_b, string tag);
        for (int i = 0; i < len; i++) begin
            cycle(1'b0, 1'b1, i == 0, seed_b + 8'(i), tag);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        int s;
        s = int'($urandom(32'd2024));
        model_clear();
        repeat (3) @(negedge clk);
        check("R7 reset state");
        rst_n = 1'b1;
        xfer_len_mode = 1'b1; ep_dir_out = 1'b1;

        // R2: offset 0 takes first byte, next byte is high
        len_ofs = 8'd0;
        cycle(1'b1, 1'b0, 1'b0, 8'h00, "R7 clear");
        send_pkt(3, 8'h41, "R2 R3 R4 offset zero");
        send_pkt(2, 8'h90, "R5 held after both");

        // R6: low at last byte, high from next packet
        len_ofs = 8'd2;
        cycle(1'b1, 1'b0, 1'b0, 8'h00, "R7 clear");
        send_pkt(3, 8'h10, "R6 low ends packet");
        send_pkt(2, 8'hA0, "R6 high from next packet");

        // R8: offset past packet end, counter restarts
        len_ofs = 8'd4;
        cycle(1'b1, 1'b0, 1'b0, 8'h00, "R7 clear");
        send_pkt(3, 8'h20, "R8 short packet no capture");
        send_pkt(6, 8'h30, "R8 restart and capture");

        // R1: mode off or IN endpoint
        len_ofs = 8'd0;
        cycle(1'b1, 1'b0, 1'b0, 8'h00, "R7 clear");
        xfer_len_mode = 1'b0;
        send_pkt(2, 8'h55, "R1 mode off");
        xfer_len_mode = 1'b1; ep_dir_out = 1'b0;
        send_pkt(2, 8'h66, "R1 IN endpoint");
        ep_dir_out = 1'b1;

        // R7: clear collides with capture of low, then of high
        len_ofs = 8'd1;
        cycle(1'b0, 1'b1, 1'b1, 8'h01, "R7 pre");
        cycle(1'b1, 1'b1, 1'b0, 8'h02, "R7 clear beats low capture");
        send_pkt(2, 8'h70, "R3 R4 after clear");
        cycle(1'b1, 1'b0, 1'b0, 8'h00, "R7 clear");
        send_pkt(2, 8'h80, "R3 low");
        cycle(1'b1, 1'b1, 1'b0, 8'h99, "R7 clear beats high capture");
        check("R9 base pass through");

        // random descriptors
        for (int k = 0; k < 300; k++) begin
            len_ofs = 8'($urandom_range(0, 5));
            xfer_len_mode = ($urandom_range(0, 9) != 0);
            ep_dir_out = ($urandom_range(0, 9) != 0);
            cycle(1'b1, 1'b0, 1'b0, 8'h00, "R7 random clear");
            for (int p = 0; p < 3; p++) begin
                int len;
                len = $urandom_range(1, 5);
                for (int i = 0; i < len; i++) begin
                    cycle($urandom_range(0, 29) == 0, 1'b1, i == 0, 8'($urandom),
                          "R3 R4 R6 R8 random");
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule